// File: doc/BRIEF.md
# Transmit DMA Fetcher with Occupancy-Threshold Refill

This block copies one outgoing packet from a paged byte-wide buffer memory into the transmit FIFO. Software first sets a start page, a 16-bit byte count written as two 8-bit halves, and a refill threshold. It then pulses the transmit command. The packet begins at byte address start page × 256. The block issues one memory read per cycle and walks upward through the addresses. Each returned byte is written into the FIFO, and the remaining-byte counter drops by one for every byte written.

The first burst runs until the FIFO is full. After that, the block refills only in bursts. A burst starts when the FIFO occupancy, counting any byte still in flight from memory, falls below the threshold. It runs until the FIFO is full again or until every byte has been requested. When loopback is selected, the FIFO is shared with the receiver, so the fill limit becomes half the depth. The block pulses done one cycle after the last byte is written and returns to idle. A command with a count of zero reports done at once and never touches memory.

Top module: `tx_dma_fetch`

## Requirements
- R1: While reset is held and after it is released, busy, done, mem_rd_en and fifo_wr_en are all 0.
- R2: The first read address is {start page, 8'h00} and each later read uses the next address. fifo_wr_en follows a read by exactly one cycle and carries the byte the memory returned.
- R3: When the FIFO is not being drained, the first burst reads back to back until the occupancy reaches the fill limit, and occupancy never exceeds that limit.
- R4: Once a burst has stopped because the FIFO is full, no read is issued while occupancy plus in-flight bytes is at or above the threshold. Reads resume once that sum falls below the threshold.
- R5: bytes_left loads with the command and drops by one on each FIFO write. Exactly the programmed number of bytes is written.
- R6: done is high for one cycle, in the cycle after the last FIFO write. busy is low in that same cycle.
- R7: A command with a count of zero raises done in the next cycle and issues no memory read.
- R8: With cfg_loopback = 1, the fill limit is FIFO_DEPTH/2 instead of FIFO_DEPTH.
- R9: A command pulse while busy is ignored: the transfer in progress, its data and bytes_left are unaffected.
- R10: The byte count is {cfg_count_hi, cfg_count_lo}, with the high register in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_xmit | input | 1 | One-cycle transmit command |
| cfg_start_page | input | 8 | Page holding the first packet byte |
| cfg_count_lo | input | 8 | Byte count, bits 7:0 |
| cfg_count_hi | input | 8 | Byte count, bits 15:8 |
| cfg_threshold | input | LVL_W | Occupancy below which a refill burst starts |
| cfg_loopback | input | 1 | Halves the FIFO fill limit |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | FIFO write byte |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete pulse |
| bytes_left | output | 16 | Bytes not yet written into the FIFO |

## Verification
The bench targets the moment the first fill ends. A design that ignores the byte in flight would overrun the FIFO by one. A design that resumes at occupancy equal to the threshold instead of below it would read while it should be waiting. Loopback runs check that filling stops at half depth, not full depth. A 261-byte count checks that the high count register is used. Zero-length, single-byte and ignored mid-transfer commands cover the cases where a design might touch memory without cause, pulse done late or twice, or reload its counters.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_HOLD  = 2'd2
  } tdf_state_e;
endpackage

// File: rtl/tdf_ptr.sv
module tdf_ptr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              issue,
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] addr,
  output logic              iss_zero
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  iss_q, iss_d;

  always_comb begin
    addr_d = addr_q;
    iss_d  = iss_q;
    if (load) begin
      addr_d = {page, {OFF_W{1'b0}}};
      iss_d  = count;
    end else if (issue) begin
      addr_d = addr_q + 1'b1;
      iss_d  = iss_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      iss_q  <= '0;
    end else if (load || issue) begin
      addr_q <= addr_d;
      iss_q  <= iss_d;
    end
  end

  assign addr     = addr_q;
  assign iss_zero = (iss_q == '0);

  // R2: consecutive reads walk upward one byte at a time
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/tdf_tally.sv
module tdf_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             wr,
  input  logic             empty_cmd,
  output logic [CNT_W-1:0] left,
  output logic             last_wr,
  output logic             done
);
  logic [CNT_W-1:0] left_q, left_d;
  logic             done_q, done_d;

  always_comb begin
    last_wr = wr && (left_q == CNT_W'(1));
    left_d  = left_q;
    if (load)    left_d = count;
    else if (wr) left_d = left_q - 1'b1;
    done_d = last_wr || empty_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (load || wr) left_q <= left_d;
      done_q <= done_d;
    end
  end

  assign left = left_q;
  assign done = done_q;

  // R5: every FIFO write takes exactly one byte off the count
  p_left_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (left_q == $past(left_q) - 1'b1));
  // R5: no write once the count is spent
  p_no_extra_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (left_q != '0));
  // R6: completion is reported only with nothing left
  p_done_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (left_q == '0));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/tdf_ctrl.sv
module tdf_ctrl
  import tdf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd,
  input  logic             count_nz,
  input  logic             iss_zero,
  input  logic             last_wr,
  input  logic             inflight,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] threshold,
  input  logic             loopback,
  output logic             load,
  output logic             empty_cmd,
  output logic             issue,
  output logic             busy
);
  localparam logic [LVL_W-1:0] FULL_LIM = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_LIM = LVL_W'(DEPTH / 2);

  tdf_state_e       st_q, st_d;
  logic [LVL_W-1:0] limit;
  logic [LVL_W:0]   fill_sum;
  logic             room;

  always_comb begin
    limit     = loopback ? HALF_LIM : FULL_LIM;
    fill_sum  = {1'b0, level} + (LVL_W+1)'(inflight);
    room      = fill_sum < {1'b0, limit};
    load      = (st_q == ST_IDLE) && cmd && count_nz;
    empty_cmd = (st_q == ST_IDLE) && cmd && !count_nz;
    issue     = (st_q == ST_BURST) && !iss_zero && room;
    st_d      = st_q;
    case (st_q)
      ST_IDLE:  if (load) st_d = ST_BURST;
      ST_BURST: begin
        if (last_wr)                st_d = ST_IDLE;
        else if (!iss_zero && !room) st_d = ST_HOLD;
      end
      ST_HOLD:  if (fill_sum < {1'b0, threshold}) st_d = ST_BURST;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);

  // R1: nothing is fetched outside a transfer
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !issue);
  // R4: a hold is left only when occupancy has fallen below the threshold
  p_hold_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |=> ((st_q == ST_HOLD) || ($past(fill_sum) < {1'b0, $past(threshold)})));
endmodule

// File: rtl/tx_dma_fetch.sv
module tx_dma_fetch #(
  parameter  int FIFO_DEPTH = 16,
  parameter  int DATA_W     = 8,
  parameter  int PAGE_W     = 8,
  parameter  int ADDR_W     = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1,
  localparam int CNT_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_xmit,
  input  logic [PAGE_W-1:0] cfg_start_page,
  input  logic [DATA_W-1:0] cfg_count_lo,
  input  logic [DATA_W-1:0] cfg_count_hi,
  input  logic [LVL_W-1:0]  cfg_threshold,
  input  logic              cfg_loopback,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_left
);
  logic [CNT_W-1:0] count;
  logic             load, empty_cmd, issue, iss_zero, last_wr;
  logic             rd_valid_q;

  assign count = {cfg_count_hi, cfg_count_lo};

  tdf_ctrl #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_xmit),
    .count_nz  (count != '0),
    .iss_zero  (iss_zero),
    .last_wr   (last_wr),
    .inflight  (rd_valid_q),
    .level     (fifo_level),
    .threshold (cfg_threshold),
    .loopback  (cfg_loopback),
    .load      (load),
    .empty_cmd (empty_cmd),
    .issue     (issue),
    .busy      (busy)
  );

  tdf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .issue    (issue),
    .page     (cfg_start_page),
    .count    (count),
    .addr     (mem_addr),
    .iss_zero (iss_zero)
  );

  tdf_tally #(.CNT_W(CNT_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .count     (count),
    .wr        (rd_valid_q),
    .empty_cmd (empty_cmd),
    .left      (bytes_left),
    .last_wr   (last_wr),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= issue;
  end

  assign mem_rd_en    = issue;
  assign fifo_wr_en   = rd_valid_q;
  assign fifo_wr_data = mem_rd_data;

  // R2: a FIFO write always answers the read of the previous cycle
  p_wr_follows_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> $past(mem_rd_en));
  // R3 / R8: a write never lands in a FIFO already at its fill limit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> (fifo_level < (cfg_loopback ? LVL_W'(FIFO_DEPTH / 2) : LVL_W'(FIFO_DEPTH))));
  // R9: a command during a transfer does not reload the count
  p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_xmit && !fifo_wr_en) |=> (bytes_left == $past(bytes_left)));
endmodule

// File: tb/tb_tx_dma_fetch.sv
module tb_tx_dma_fetch;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_xmit;
  logic [7:0]       cfg_start_page, cfg_count_lo, cfg_count_hi;
  logic [LVL_W-1:0] cfg_threshold;
  logic             cfg_loopback;
  logic             mem_rd_en;
  logic [15:0]      mem_addr;
  logic [7:0]       mem_rd_data;
  logic             fifo_wr_en;
  logic [7:0]       fifo_wr_data;
  logic [LVL_W-1:0] lvl;
  logic             busy, done;
  logic [15:0]      bytes_left;
  logic             drain;

  int tests = 0, fails = 0;
  int rd_cnt = 0, done_cnt = 0;
  logic [7:0] q[$];
  logic       chk_left_pend = 1'b0, chk_done_pend = 1'b0;
  int         exp_left_v = 0;

  always #10 clk = ~clk;

  tx_dma_fetch #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_xmit(cmd_xmit),
    .cfg_start_page(cfg_start_page), .cfg_count_lo(cfg_count_lo),
    .cfg_count_hi(cfg_count_hi), .cfg_threshold(cfg_threshold),
    .cfg_loopback(cfg_loopback), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_level(lvl), .busy(busy),
    .done(done), .bytes_left(bytes_left)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h5A);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_f(mem_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else lvl <= lvl + LVL_W'(fifo_wr_en) - LVL_W'(drain && (lvl != '0));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_left_pend) begin
        check(bytes_left == 16'(exp_left_v), "R5", "bytes_left after write", bytes_left, exp_left_v);
        chk_left_pend = 1'b0;
      end
      if (chk_done_pend) begin
        check(done && !busy, "R6", "done/!busy after last write", {busy, done}, 1);
        chk_done_pend = 1'b0;
      end
      if (done) done_cnt++;
      if (mem_rd_en) rd_cnt++;
      if (fifo_wr_en) begin
        check(lvl < (cfg_loopback ? LVL_W'(DEPTH/2) : LVL_W'(DEPTH)), "R3", "level at write", lvl,
              cfg_loopback ? DEPTH/2 - 1 : DEPTH - 1);
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected FIFO write", 1, 0);
        end else begin
          logic [7:0] e;
          e = q.pop_front();
          check(fifo_wr_data == e, "R2", "FIFO byte", fifo_wr_data, e);
          exp_left_v = q.size();
          chk_left_pend = 1'b1;
          if (q.size() == 0) chk_done_pend = 1'b1;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic start_xfer(input logic [7:0] page, input logic [15:0] cnt,
                            input int thr, input bit lb);
    cfg_start_page = page;
    cfg_count_hi   = cnt[15:8];
    cfg_count_lo   = cnt[7:0];
    cfg_threshold  = LVL_W'(thr);
    cfg_loopback   = lb;
    for (int i = 0; i < int'(cnt); i++) q.push_back(mem_f({page, 8'h00} + 16'(i)));
    cmd_xmit = 1'b1;
    step();
    cmd_xmit = 1'b0;
  endtask

  task automatic wait_finish();
    for (int i = 0; i < 3000; i++) begin
      if (!busy && q.size() == 0) break;
      step();
    end
    step(); step();
    check(q.size() == 0 && !busy, "R5", "transfer completed", q.size(), 0);
  endtask

  task automatic empty_fifo();
    drain = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (lvl == '0) break;
      step();
    end
    drain = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cmd_xmit = 1'b0; drain = 1'b0;
    cfg_start_page = '0; cfg_count_lo = '0; cfg_count_hi = '0;
    cfg_threshold = '0; cfg_loopback = 1'b0;
    repeat (3) step();
    check(!busy && !done && !mem_rd_en && !fifo_wr_en, "R1", "outputs in reset",
          {busy, done, mem_rd_en, fifo_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) step();
    check(!busy && !done && !mem_rd_en && !fifo_wr_en, "R1", "outputs after reset",
          {busy, done, mem_rd_en, fifo_wr_en}, 0);

    // normal mode: initial fill, hold, threshold refill, ignored command
    base = rd_cnt;
    start_xfer(8'h12, 16'd40, 4, 1'b0);
    repeat (30) step();
    check(lvl == LVL_W'(DEPTH), "R3", "first fill reaches full", lvl, DEPTH);
    check(rd_cnt - base == DEPTH, "R3", "reads in first fill", rd_cnt - base, DEPTH);
    drain = 1'b1; repeat (11) step(); drain = 1'b0;
    repeat (6) step();
    check(rd_cnt - base == DEPTH, "R4", "no read at level above threshold", rd_cnt - base, DEPTH);
    check(lvl == 5, "R4", "level held", lvl, 5);
    drain = 1'b1; repeat (2) step(); drain = 1'b0;
    repeat (4) step();
    check(rd_cnt - base > DEPTH, "R4", "refill after dropping below threshold", rd_cnt - base, DEPTH + 1);
    cfg_start_page = 8'h33; cfg_count_hi = 8'h00; cfg_count_lo = 8'h05;
    cmd_xmit = 1'b1; step(); cmd_xmit = 1'b0;
    check(bytes_left == 16'(q.size()), "R9", "count unchanged by busy command", bytes_left, q.size());
    drain = 1'b1;
    wait_finish();
    empty_fifo();

    // loopback with a count using the high byte
    base = rd_cnt;
    start_xfer(8'h80, 16'h0105, 2, 1'b1);
    repeat (20) step();
    check(lvl == LVL_W'(DEPTH/2), "R8", "loopback fill limit", lvl, DEPTH/2);
    check(rd_cnt - base == DEPTH/2, "R8", "loopback reads", rd_cnt - base, DEPTH/2);
    drain = 1'b1;
    wait_finish();
    check(rd_cnt - base == 261, "R10", "reads for 16'h0105", rd_cnt - base, 261);
    empty_fifo();

    // zero count
    base = rd_cnt;
    cfg_count_hi = 8'h00; cfg_count_lo = 8'h00; cfg_loopback = 1'b0;
    cmd_xmit = 1'b1; step(); cmd_xmit = 1'b0;
    check(done && !busy, "R7", "done right after zero command", {busy, done}, 1);
    repeat (5) step();
    check(rd_cnt == base, "R7", "no memory read for zero count", rd_cnt - base, 0);

    // single byte from the top page
    base = rd_cnt;
    start_xfer(8'hFF, 16'd1, 1, 1'b0);
    wait_finish();
    check(rd_cnt - base == 1, "R2", "single read", rd_cnt - base, 1);
    empty_fifo();

    check(done_cnt == 4, "R6", "done pulses", done_cnt, 4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule